// File: doc/BRIEF.md
# SHA-256 Four-Lane Message Schedule Expander

This block turns one 512-bit SHA-256 message block into the full 64-word schedule and delivers it as sixteen groups of four 32-bit words. It produces a group in each clock cycle. The recurrence is split into two lane-parallel stages. The first stage adds σ0 of each word's upper neighbour to the word. The second stage folds in the realigned words seven places back and then adds σ1 of the word two places back. Within one group, the two upper lanes take their σ1 operand directly from the two lower lanes' fresh results.

A round engine loads a block by pulsing `start` with all sixteen words present on `blk_words`. Word t sits at bits [32t+31:32t]. The schedule then leaves on a valid/ready stream:

- A group transfers on every cycle in which `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the offered group is held unchanged.
- `out_ready` may be tied high. The block never waits on anything else.
- `start` is a plain control strobe. It is not handshaked, and it always wins over the stream.

Top module: `msv_sched`

## Requirements
- R1: After reset, and until the first `start`, `out_valid` is low.
- R2: The cycle after `start` is sampled high, `out_valid` is high and `out_group` is 0.
- R3: Groups 0 to 3 carry the input words w0..w15 unchanged. Group g lane j, at `out_data` bits [32j+31:32j], is word 4g+j.
- R4: Groups 4 to 15 carry w16..w63, where w[t] = w[t-16] + σ0(w[t-15]) + w[t-7] + σ1(w[t-2]) modulo 2^32. Here σ0(x) = ROTR7 ^ ROTR18 ^ SHR3 and σ1(x) = ROTR17 ^ ROTR19 ^ SHR10.
- R5: In every computed group, lanes 2 and 3 use that same group's lane 0 and lane 1 results as their σ1 operands.
- R6: Each accepted transfer advances `out_group` by one, from 0 to 15. After the transfer of group 15, `out_valid` drops. Exactly 16 transfers occur per block.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_group` stay unchanged into the next cycle.
- R8: A `start` during a block in progress abandons it. The next cycle offers group 0 of the newly loaded words, even if a transfer happened in the same cycle as the `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `blk_words` and restart the schedule |
| blk_words | input | 512 | Sixteen input words, word t at bits [32t+31:32t] |
| out_valid | output | 1 | A schedule group is offered |
| out_ready | input | 1 | Consumer accepts the offered group |
| out_data | output | 128 | Four schedule words, lane j at bits [32j+31:32j] |
| out_group | output | 4 | Index of the offered group, 0 to 15 |

## Verification
The bench recomputes the schedule one word at a time for a sweep of blocks: all zeros, all ones, a counting pattern and many pseudo-random blocks. The consumer sees each block under several ready patterns.

- A missed lane-2/3 chaining (R5), where old window words feed σ1, corrupts lanes 2 and 3 from group 4 onward.
- A wrong rotation or window offset corrupts every computed group (R4).
- Sliding the window while stalled would skip or duplicate groups during back-pressure (R6, R7).
- Letting a transfer win over a restart would resume the old block instead of offering group 0 of the new words (R8).

// File: rtl/msv_pkg.sv
`timescale 1ns/1ps
package msv_pkg;
  localparam int WORD_W = 32;
  localparam int WIN_WORDS = 16;
  localparam int SCHED_WORDS = 64;

  typedef logic [WORD_W-1:0] word_t;

  // lower-case sigma 0: rotate 7, rotate 18, shift 3
  function automatic word_t lsig0(word_t x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x >> 3);
  endfunction

  // lower-case sigma 1: rotate 17, rotate 19, shift 10
  function automatic word_t lsig1(word_t x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x >> 10);
  endfunction
endpackage

// File: rtl/msv_pre.sv
`timescale 1ns/1ps
// First stage: each lane adds sigma0 of its upper neighbour to its own word.
module msv_pre
  import msv_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0][WORD_W-1:0] seg,
  output logic [LANES-1:0][WORD_W-1:0]   part
);
  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      assign part[j] = seg[j] + lsig0(seg[j+1]);
    end
  endgenerate
endmodule

// File: rtl/msv_post.sv
`timescale 1ns/1ps
// Realign-and-add of the words seven back, then the sigma1 post-add.
// A lane whose sigma1 operand lies beyond the window chains off a lower lane
// of the same step.
module msv_post
  import msv_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIN   = 16
) (
  input  logic [WIN-1:0][WORD_W-1:0]   win,
  input  logic [LANES-1:0][WORD_W-1:0] part,
  output logic [LANES-1:0][WORD_W-1:0] fresh
);
  localparam int FAR_OFS = WIN - 7;  // word t-7 relative to window base
  localparam int S1_OFS  = WIN - 2;  // word t-2 relative to window base

  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      word_t mid;
      word_t s1_src;
      word_t res;

      assign mid = part[j] + win[FAR_OFS + j];

      if (S1_OFS + j < WIN) begin : g_from_win
        assign s1_src = win[S1_OFS + j];
      end else begin : g_from_lane
        assign s1_src = g_lane[j - 2].res;
      end

      assign res      = mid + lsig1(s1_src);
      assign fresh[j] = res;
    end
  endgenerate
endmodule

// File: rtl/msv_window.sv
`timescale 1ns/1ps
// Sixteen-word sliding window. Word 0 is the oldest word.
module msv_window
  import msv_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIN   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         adv,
  input  logic [WIN-1:0][WORD_W-1:0]   blk,
  input  logic [LANES-1:0][WORD_W-1:0] fresh,
  output logic [WIN-1:0][WORD_W-1:0]   win
);
  logic [WIN-1:0][WORD_W-1:0] slid;

  genvar k;
  generate
    for (k = 0; k < WIN; k++) begin : g_slot
      if (k < WIN - LANES) begin : g_keep
        assign slid[k] = win[k + LANES];
      end else begin : g_new
        assign slid[k] = fresh[k - (WIN - LANES)];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (load) begin
      win <= blk;
    end else if (adv) begin
      win <= slid;
    end
  end
endmodule

// File: rtl/msv_sched.sv
`timescale 1ns/1ps
module msv_sched
  import msv_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start,
  input  logic [WIN_WORDS*WORD_W-1:0]                   blk_words,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [LANES*WORD_W-1:0]                       out_data,
  output logic [$clog2(SCHED_WORDS/LANES)-1:0]          out_group
);
  localparam int WIN    = WIN_WORDS;
  localparam int GROUPS = SCHED_WORDS / LANES;
  localparam int GW     = $clog2(GROUPS);
  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  logic [WIN-1:0][WORD_W-1:0]   win;
  logic [LANES-1:0][WORD_W-1:0] part;
  logic [LANES-1:0][WORD_W-1:0] fresh;
  logic [WIN-1:0][WORD_W-1:0]   blk_arr;
  logic                         busy;
  logic [GW-1:0]                grp;
  logic                         fire;

  assign blk_arr = blk_words;
  assign fire    = busy && out_ready;

  msv_pre #(.LANES(LANES)) u_pre (
    .seg  (win[2*LANES-1:0]),
    .part (part)
  );

  msv_post #(.LANES(LANES), .WIN(WIN)) u_post (
    .win   (win),
    .part  (part),
    .fresh (fresh)
  );

  msv_window #(.LANES(LANES), .WIN(WIN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .adv   (fire && !start),
    .blk   (blk_arr),
    .fresh (fresh),
    .win   (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      grp  <= '0;
    end else if (fire) begin
      if (grp == LAST_GRP) busy <= 1'b0;
      grp <= grp + 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_group = grp;
  assign out_data  = win[LANES-1:0];

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_valid && out_group == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_data) && $stable(out_group)));

  // R6
  grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !start && out_group != LAST_GRP) |=>
      (out_valid && out_group == GW'($past(out_group) + 1'b1)));

  // R6
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !start && out_group == LAST_GRP) |=> !out_valid);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !start) |=> !out_valid);
endmodule

// File: tb/msv_sched_test.sv
`timescale 1ns/1ps
module msv_sched_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] blk_words = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic [3:0]   out_group;

  int total = 0;
  int bad   = 0;
  logic [31:0] ex [64];
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  msv_sched uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .blk_words (blk_words),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_group (out_group)
  );

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic compute(input logic [511:0] b);
    for (int t = 0; t < 16; t++) ex[t] = b[32*t +: 32];
    for (int t = 16; t < 64; t++) begin
      logic [31:0] s0, s1;
      s0 = rr(ex[t-15], 7) ^ rr(ex[t-15], 18) ^ (ex[t-15] >> 3);
      s1 = rr(ex[t-2], 17) ^ rr(ex[t-2], 19) ^ (ex[t-2] >> 10);
      ex[t] = ex[t-16] + s0 + ex[t-7] + s1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic bit pick(int mode, int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return (cyc % 3) != 0;
      default: return nxt() >> 31;
    endcase
  endfunction

  task automatic run_block(input logic [511:0] b, input int mode, input int stop_after);
    int idx = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [127:0] held_d;
    logic [3:0]   held_g;
    logic [127:0] expv;
    compute(b);
    blk_words = b;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (idx < stop_after && cyc < 400) begin
      out_ready = pick(mode, cyc);
      @(negedge clk);
      if (cyc == 0) chk(out_valid && out_group == 4'd0, "R2/R8", {out_valid, out_group}, 128'h10);
      if (stalled) chk(out_data == held_d && out_group == held_g && out_valid, "R7", out_data, held_d);
      chk(out_valid, "R6 valid", out_valid, 1);
      if (out_ready) begin
        expv = {ex[4*idx+3], ex[4*idx+2], ex[4*idx+1], ex[4*idx]};
        chk(out_group == idx[3:0], "R6 group", out_group, idx);
        if (idx < 4) chk(out_data == expv, "R3", out_data, expv);
        else begin
          chk(out_data[63:0] == expv[63:0], "R4", out_data[63:0], expv[63:0]);
          chk(out_data[127:64] == expv[127:64], "R5", out_data[127:64], expv[127:64]);
        end
        idx++;
        stalled = 0;
      end else begin
        stalled = 1;
        held_d = out_data;
        held_g = out_group;
      end
      @(posedge clk); #1;
      cyc++;
    end
    if (cyc >= 400) chk(0, "watchdog block", cyc, 0);
    if (stop_after == 16) begin
      @(negedge clk);
      chk(!out_valid, "R6 end", out_valid, 0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1", out_valid, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1 idle", out_valid, 0);
    @(posedge clk); #1;

    run_block('0, 0, 16);
    run_block({512{1'b1}}, 1, 16);
    for (int t = 0; t < 16; t++) b[32*t +: 32] = 32'(t) * 32'h0101_0101 + 32'h8000_0001;
    run_block(b, 2, 16);

    for (int n = 0; n < 24; n++) begin
      for (int t = 0; t < 16; t++) b[32*t +: 32] = nxt();
      run_block(b, n % 4, 16);
    end

    // R8: restart mid-block, with ready held high at the restart
    for (int t = 0; t < 16; t++) b[32*t +: 32] = nxt();
    run_block(b, 0, 5);
    for (int t = 0; t < 16; t++) b[32*t +: 32] = nxt();
    run_block(b, 3, 16);
    // R8: restart during a stall
    for (int t = 0; t < 16; t++) b[32*t +: 32] = nxt();
    run_block(b, 1, 9);
    out_ready = 1'b0;
    for (int t = 0; t < 16; t++) b[32*t +: 32] = nxt();
    run_block(b, 2, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule